// File: doc/BRIEF.md
# Auto-Increment Packet Data Port

This block gives a host byte-wide access to a small packet memory of four 2 KB pages. The access goes through a 16-bit pointer register and a group of four data byte offsets. The pointer carries three things:

- an 11-bit byte address within a page;
- a flag that picks the target page: either the page at the head of the receive queue or the page named by the packet number;
- a flag that picks the addressing mode: post-increment, or fixed pointer plus data-offset lane.

The receive-head page and the packet number come in as inputs. Queue management lives elsewhere. The host drives a single-cycle request with a 4-bit register offset. Read data for any offset comes back on the next cycle. In post-increment mode the host can stream a whole frame through one data offset. In lane mode it can reach up to four bytes around a fixed pointer without touching the pointer.

Top module: `pkt_data_port`

## Requirements
- R1: After reset the pointer is zero, so reads of offsets 6 and 7 return 0x00.
- R2: The pointer is written one byte at a time: offset 6 holds bits 7:0 and offset 7 holds bits 15:8. A read of offset 7 returns bits 15:8 with its bit 3 (pointer bit 11) forced to zero. A read of offset 6 returns bits 7:0 unchanged.
- R3: A data access (offsets 8 to 11) goes to the receive-head page when pointer bit 15 is 1, and to the packet-number page when it is 0.
- R4: The byte address within the page comes from pointer bits 10:0.
- R5: When pointer bit 14 is 1, a data read or write uses the current address and then adds one to pointer bits 10:0. The offset lane has no effect, and a read returns the byte at the address before the increment.
- R6: The increment in R5 wraps from 0x7FF to 0x000, and pointer bits 15:11 keep their value.
- R7: When pointer bit 14 is 0, a data access uses pointer bits 10:0 plus offset bits 1:0, wrapping within 11 bits, and the pointer does not change.
- R8: Read data appears on rdata_o together with rvalid_o exactly one cycle after a read request. rvalid_o is low after any cycle without a read request.
- R9: A write to an offset outside 6 to 11 changes neither the pointer nor the memory. A read of such an offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_head_i | input | 2 | Page at the head of the receive queue |
| pkt_num_i | input | 2 | Page held in the packet number register |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register offset (6/7 pointer, 8..11 data) |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, one cycle after the request |
| rvalid_o | output | 1 | Read data valid |

## Verification
A pointer that steps when it should not, or fails to step, shows up at the port at once. The next pointer read returns a shifted value, and the next data read returns a byte from a neighbouring address. Both are visible within one access. A wrong page select or a broken wrap sends writes to the wrong place. This shows only when the bench later reads that location back, so the bench writes a distinct known pattern on each page and at both ends of the 11-bit range. It then reads every location back through the other addressing mode.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  localparam int PTR_W    = 16;
  localparam int OFF_W    = 11;   // byte address field
  localparam int PAGE_BIT = 15;   // 1: receive-head page
  localparam int AUTO_BIT = 14;   // 1: post-increment
  localparam logic [7:0] HI_RD_MASK = 8'hF7;
  localparam logic [3:0] OFS_PTR_LO = 4'd6;
  localparam logic [3:0] OFS_PTR_HI = 4'd7;
  localparam logic [1:0] OFS_DATA   = 2'b10; // addr[3:2] for offsets 8..11
endpackage

// File: rtl/pdp_ptr_reg.sv
module pdp_ptr_reg
  import pdp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [7:0]       wdata_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [OFF_W-1:0] off_inc;

  assign off_inc = ptr_q[OFF_W-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (wr_lo_i) begin
      ptr_q[7:0] <= wdata_i;
    end else if (wr_hi_i) begin
      ptr_q[15:8] <= wdata_i;
    end else if (step_i) begin
      ptr_q[OFF_W-1:0] <= off_inc;  // upper bits held
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/pdp_addr_gen.sv
module pdp_addr_gen
  import pdp_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [1:0]        lane_i,
  input  logic [PAGE_W-1:0] rx_head_i,
  input  logic [PAGE_W-1:0] pkt_num_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFF_W-1:0]  byte_o
);
  assign page_o = ptr_i[PAGE_BIT] ? rx_head_i : pkt_num_i;
  assign byte_o = ptr_i[AUTO_BIT] ? ptr_i[OFF_W-1:0]
                                  : ptr_i[OFF_W-1:0] + OFF_W'(lane_i);
endmodule

// File: rtl/pdp_page_ram.sv
module pdp_page_ram #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [3:0]    be_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  localparam int WORDS = 1 << AW;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (en_i) begin
        if (we_i && be_i[l]) mem[addr_i] <= wdata_i[8*l +: 8];
        else if (!we_i)      rd_q <= mem[addr_i];
      end
    end
    assign rdata_o[8*l +: 8] = rd_q;
  end
endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port
  import pdp_pkg::*;
#(
  parameter int NUM_PAGES = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(NUM_PAGES)-1:0] rx_head_i,
  input  logic [$clog2(NUM_PAGES)-1:0] pkt_num_i,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [3:0]                   addr_i,
  input  logic [7:0]                   wdata_i,
  output logic [7:0]                   rdata_o,
  output logic                         rvalid_o
);
  localparam int PAGE_W = $clog2(NUM_PAGES);
  localparam int WAW    = PAGE_W + OFF_W - 2;

  logic [PTR_W-1:0]  ptr_q;
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  byte_addr;
  logic              data_acc, step, wr_lo, wr_hi;
  logic [31:0]       ram_rdata;
  logic [7:0]        reg_rd_d, reg_rd_q;
  logic              rvalid_q, from_ram_q;
  logic [1:0]        lane_q;

  assign data_acc = req_i && (addr_i[3:2] == OFS_DATA);
  assign step     = data_acc && ptr_q[AUTO_BIT];
  assign wr_lo    = req_i && we_i && (addr_i == OFS_PTR_LO);
  assign wr_hi    = req_i && we_i && (addr_i == OFS_PTR_HI);

  pdp_ptr_reg u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (wdata_i),
    .step_i  (step),
    .ptr_o   (ptr_q)
  );

  pdp_addr_gen #(.PAGE_W(PAGE_W)) u_agen (
    .ptr_i     (ptr_q),
    .lane_i    (addr_i[1:0]),
    .rx_head_i (rx_head_i),
    .pkt_num_i (pkt_num_i),
    .page_o    (page),
    .byte_o    (byte_addr)
  );

  pdp_page_ram #(.AW(WAW)) u_ram (
    .clk_i   (clk_i),
    .en_i    (data_acc),
    .we_i    (we_i),
    .be_i    (4'b0001 << byte_addr[1:0]),
    .addr_i  ({page, byte_addr[OFF_W-1:2]}),
    .wdata_i ({4{wdata_i}}),
    .rdata_o (ram_rdata)
  );

  always_comb begin
    unique case (addr_i)
      OFS_PTR_LO: reg_rd_d = ptr_q[7:0];
      OFS_PTR_HI: reg_rd_d = ptr_q[15:8] & HI_RD_MASK;
      default:    reg_rd_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q   <= 1'b0;
      from_ram_q <= 1'b0;
      lane_q     <= '0;
      reg_rd_q   <= '0;
    end else begin
      rvalid_q   <= req_i && !we_i;
      from_ram_q <= data_acc && !we_i;
      if (req_i && !we_i) begin
        lane_q   <= byte_addr[1:0];
        reg_rd_q <= reg_rd_d;
      end
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = from_ram_q ? ram_rdata[8*lane_q +: 8] : reg_rd_q;
endmodule

// File: rtl/pdp_checker.sv
module pdp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [3:0]  addr_i,
  input logic [7:0]  rdata_o,
  input logic        rvalid_o,
  input logic [15:0] ptr_q
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R8
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o); // R8
  AST_PTR_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(ptr_q)); // R9
  AST_LANE_PTR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[3:2] == 2'b10 && !ptr_q[14]) |=> $stable(ptr_q)); // R7
  AST_AUTO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[3:2] == 2'b10 && ptr_q[14])
      |=> (ptr_q[10:0] == $past(ptr_q[10:0]) + 11'd1)
          && (ptr_q[15:11] == $past(ptr_q[15:11]))); // R6
  AST_HI_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 4'd7) |=> (rdata_o[3] == 1'b0)); // R2
endmodule

bind pkt_data_port pdp_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .ptr_q    (ptr_q)
);

// File: tb/pkt_data_port_test.sv
module pkt_data_port_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] rx_head_i = '0, pkt_num_i = '0;
  logic       req_i = 1'b0, we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rvalid_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pkt_data_port uut (.*);

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%02h expected 0x%02h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = off; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = off;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    wr(4'd6, p[7:0]);
    wr(4'd7, p[15:8]);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'd6, v); chk("R1 ptr lo", v, 8'h00);
    rd(4'd7, v); chk("R1 ptr hi", v, 8'h00);
  endtask

  task automatic t_ptr_bytes();
    logic [7:0] v;
    set_ptr(16'h5A34);
    rd(4'd6, v); chk("R2 ptr lo", v, 8'h34);
    rd(4'd7, v); chk("R2 ptr hi masked", v, 8'h52);
  endtask

  task automatic t_autoinc();
    logic [7:0] v;
    pkt_num_i = 2'd1;
    set_ptr(16'h4010);
    wr(4'd8, 8'h11); wr(4'd8, 8'h22); wr(4'd8, 8'h33);
    rd(4'd6, v); chk("R5 ptr after writes", v, 8'h13);
    set_ptr(16'h4010);
    rd(4'd9, v);  chk("R5 read 0", v, 8'h11);
    rd(4'd11, v); chk("R5 read 1", v, 8'h22);
    rd(4'd10, v); chk("R4 read 2", v, 8'h33);
    rd(4'd6, v); chk("R5 ptr after reads", v, 8'h13);
  endtask

  task automatic t_lane();
    logic [7:0] v;
    set_ptr(16'h0010);
    rd(4'd8, v);  chk("R7 lane0", v, 8'h11);
    rd(4'd9, v);  chk("R7 lane1", v, 8'h22);
    rd(4'd10, v); chk("R7 lane2", v, 8'h33);
    wr(4'd11, 8'h44);
    rd(4'd6, v); chk("R7 ptr held", v, 8'h10);
    set_ptr(16'h4013);
    rd(4'd8, v); chk("R7 lane3 write", v, 8'h44);
  endtask

  task automatic t_page();
    logic [7:0] v;
    rx_head_i = 2'd2;
    set_ptr(16'hC010);
    wr(4'd8, 8'hA5);
    rd(4'd7, v); chk("R3 ptr hi", v, 8'hC0);
    pkt_num_i = 2'd2; set_ptr(16'h4010);
    rd(4'd8, v); chk("R3 rx page via pkt num", v, 8'hA5);
    pkt_num_i = 2'd1; set_ptr(16'h4010);
    rd(4'd8, v); chk("R3 other page intact", v, 8'h11);
    rx_head_i = 2'd1; set_ptr(16'h8010);
    rd(4'd8, v); chk("R3 rx head select", v, 8'h11);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    pkt_num_i = 2'd1;
    set_ptr(16'h4000); wr(4'd8, 8'hC3);
    set_ptr(16'h7FFF); wr(4'd8, 8'hBE);
    rd(4'd6, v); chk("R6 wrap lo", v, 8'h00);
    rd(4'd7, v); chk("R6 upper kept", v, 8'h70);
    set_ptr(16'h07FF);
    rd(4'd8, v); chk("R4 top byte", v, 8'hBE);
    rd(4'd9, v); chk("R7 lane wrap", v, 8'hC3);
    rd(4'd6, v); chk("R7 ptr lo held", v, 8'hFF);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    @(negedge clk_i);
    chk("R8 idle rvalid", {7'd0, rvalid_o}, 8'h00);
    rd(4'd6, v);
    chk("R8 rvalid after read", {7'd0, rvalid_o}, 8'h01);
    wr(4'd2, 8'h00);
    chk("R8 rvalid after write", {7'd0, rvalid_o}, 8'h00);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    set_ptr(16'h4010);
    wr(4'd2, 8'hFF); wr(4'd0, 8'hEE); wr(4'd13, 8'hDD);
    rd(4'd6, v); chk("R9 ptr lo kept", v, 8'h10);
    rd(4'd7, v); chk("R9 ptr hi kept", v, 8'h40);
    rd(4'd2, v); chk("R9 other reads zero", v, 8'h00);
    rd(4'd8, v); chk("R9 memory kept", v, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ptr_bytes();
    t_autoinc();
    t_lane();
    t_page();
    t_wrap();
    t_latency();
    t_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule